// File: doc/BRIEF.md
# Multi-queue inter-processor message mailbox

The block lets several processors, called users, pass 32-bit words to one another through a bank of small hardware queues behind one synchronous register port. A processor sends by writing a word to a queue's message register and receives by reading the same register, which returns the oldest word and removes it. Each queue has two read-only status registers: one says whether the queue is full and one gives how many words it holds.

Every queue raises two events: a new-message event on each accepted write and a not-full event on each accepted read. Both events are posted to every user's interrupt status word. Each user has its own status register, cleared by writing ones, and an enable mask that is changed through separate set and clear registers. The user's interrupt line is high while any enabled status bit is set, so any processor can be told about traffic on any queue.

The register port has one address. Read data is combinational and valid in the same cycle as `bus_rd`; the side effect of a read, such as removing a word from a queue, takes place at the next rising clock edge. A read and a write may be issued together to the same address.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous active-low reset, every queue is empty, every status and enable bit is 0 and every `irq` line is low.
- R2: Byte address 0x000 reads the constant `REVISION` (default 0x0004_0100). Writes to it have no effect.
- R3: The message register of queue m is at byte address 0x040 + 4·m. A write appends the word and a read returns the oldest word and removes it. Each queue holds `DEPTH` words (default 4) in first-in first-out order.
- R4: A write to a full queue is dropped. A read of an empty queue returns 0 and leaves the queue unchanged.
- R5: Byte address 0x080 + 4·m reads 1 when queue m holds `DEPTH` words and reads 0 otherwise.
- R6: Byte address 0x0C0 + 4·m reads the number of words in queue m, from 0 to `DEPTH`.
- R7: In every user's status word, bit 2·m is set on each accepted write to queue m and bit 2·m+1 is set on each accepted read from queue m. These bits are set for all users.
- R8: The status register of user u is at 0x104 + 0x10·u. Writing 1 to a bit clears that bit and writing 0 leaves it unchanged. An event in the same cycle sets the bit even if the write clears it.
- R9: User u's enable-set register is at 0x108 + 0x10·u and its enable-clear register is at 0x10C + 0x10·u. Writing 1 to a bit sets or clears that enable bit. Reading either register returns the enable mask.
- R10: `irq[u]` is high exactly when user u's status AND enable mask is nonzero.
- R11: Unmapped or misaligned addresses read 0 and ignore writes. This covers queue indices at or above `NUM_QUEUES`, user indices at or above `NUM_USERS`, offset 0x100 + 0x10·u and any address whose low two bits are nonzero.
- R12: A write and a read to the same message register in one cycle append and remove one word each, so the count stays the same and the read returns the previous head. If the queue was empty, the read returns 0 and the written word is kept. If the queue was full, the write is dropped and the read still removes a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; a read of a message register removes a word |
| bus_rdata | output | DATA_W | Read data, valid while `bus_rd` is high; 0 otherwise |
| irq | output | NUM_USERS | Per-user interrupt level |

## Verification
The bench targets several corner cases, each with the failure it would catch:
- Writing a full queue: a design that accepted the write would overwrite the head, corrupt the count and raise a new-message bit that should not appear.
- Reading an empty queue: a design that moved the read pointer would shift every later word by one position.
- A read and a write together: on an empty queue a wrong design returns stale storage, on a full queue it loses the popped slot, and in either case the count can drift by one.
- Status clearing: writing zeros to the status register must leave the bits set, and a broken clear would either wipe all bits or leave the interrupt line stuck high.
- Unmapped addresses: the bench writes ones to the gaps between user blocks and to a queue index past the last one, then reads back the real registers. A decoder that aliases those addresses would change the enable masks or push stray words.

// File: rtl/mbx_pkg.sv
// Shared constants for the mailbox: address pages and user register kinds.
// Assumes byte addressing with word-aligned (4-byte) registers.
package mbx_pkg;
    localparam int PAGE_MSG   = 1;      // 0x040 page: message registers
    localparam int PAGE_FULL  = 2;      // 0x080 page: full flags
    localparam int PAGE_COUNT = 3;      // 0x0C0 page: occupancy
    localparam int USER_BASE  = 'h100;  // user blocks start here, 0x10 apart

    typedef enum logic [1:0] {
        UREG_NONE   = 2'd0,
        UREG_STATUS = 2'd1,
        UREG_ENSET  = 2'd2,
        UREG_ENCLR  = 2'd3
    } ureg_e;
endpackage

// File: rtl/mbx_queue.sv
// One message queue: DEPTH-entry circular buffer with an occupancy count.
// Assumes push and pop are already qualified only by the address decode.
// Full/empty rejection happens here. head_o is meaningful only when count_o > 0.
module mbx_queue #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CW-1:0]     count_o,
    output logic              push_ok_o,
    output logic              pop_ok_o
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;

    // acceptance is judged on the state before the edge
    assign push_ok_o = push_i && (count != CW'(DEPTH));
    assign pop_ok_o  = pop_i  && (count != '0);
    assign head_o    = mem[rd_ptr];
    assign count_o   = count;

    // storage write on an accepted push
    always_ff @(posedge clk) begin
        if (push_ok_o) mem[wr_ptr] <= data_i;
    end

    // pointer and count bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok_o)
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok_o)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok_o, pop_ok_o})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && count == CW'(DEPTH)) |=> $stable(count));
    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && count == '0) |=> (count == '0));
    assert_rw_balance_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && count != '0 && count != CW'(DEPTH)) |=> $stable(count));
endmodule

// File: rtl/mbx_user_irq.sv
// Per-user interrupt block: status bits set by queue events and cleared by
// writing ones, an enable mask changed by set/clear strobes, and a level IRQ.
// Assumes at most one of the three write strobes is high per cycle.
module mbx_user_irq #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] evt_i,
    input  logic          w1c_we_i,
    input  logic          set_we_i,
    input  logic          clr_we_i,
    input  logic [IW-1:0] wdata_i,
    output logic [IW-1:0] status_o,
    output logic [IW-1:0] enable_o,
    output logic          irq_o
);
    logic [IW-1:0] status, enable;

    // status: hardware events win over a same-cycle software clear
    always_ff @(posedge clk) begin
        if (!rst_n)         status <= '0;
        else if (w1c_we_i)  status <= (status & ~wdata_i) | evt_i;
        else                status <= status | evt_i;
    end

    // enable mask: separate set and clear strobes
    always_ff @(posedge clk) begin
        if (!rst_n)         enable <= '0;
        else if (set_we_i)  enable <= enable | wdata_i;
        else if (clr_we_i)  enable <= enable & ~wdata_i;
    end

    assign status_o = status;
    assign enable_o = enable;
    assign irq_o    = |(status & enable);

    assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status & $past(evt_i)) == $past(evt_i)));
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_we_i && evt_i == '0) |=> (status == ($past(status) & ~$past(wdata_i))));
    assert_enset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_i |=> ((enable & $past(wdata_i)) == $past(wdata_i)));
    assert_enclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((enable & $past(wdata_i)) == '0));
    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(evt_i) != '0 || $past(set_we_i)));
endmodule

// File: rtl/ipc_mailbox.sv
// Mailbox top: address decode, read multiplexer, a bank of queues and one
// interrupt block per user. Assumes word-aligned byte addresses; read data is
// combinational and read side effects land on the next rising edge.
module ipc_mailbox #(
    parameter int          NUM_USERS  = 4,
    parameter int          NUM_QUEUES = 8,
    parameter int          DEPTH      = 4,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 12,
    parameter logic [31:0] REVISION   = 32'h0004_0100,
    localparam int         IW         = 2 * NUM_QUEUES,
    localparam int         CW         = $clog2(DEPTH + 1),
    localparam int         PGW        = ADDR_W - 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_rd,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_USERS-1:0] irq
);
    import mbx_pkg::*;

    logic              aligned;
    logic [PGW-1:0]    page;
    logic [3:0]        qsel;
    logic [ADDR_W-1:0] uoff;
    logic [ADDR_W-5:0] usel;
    ureg_e             ukind;
    logic              in_user_space;

    logic [DATA_W-1:0] q_head  [NUM_QUEUES];
    logic [CW-1:0]     q_count [NUM_QUEUES];
    logic [NUM_QUEUES-1:0] q_push, q_pop, q_push_ok, q_pop_ok;
    logic [IW-1:0]     evt;

    logic [IW-1:0]     u_status [NUM_USERS];
    logic [IW-1:0]     u_enable [NUM_USERS];
    logic [NUM_USERS-1:0] u_w1c, u_set, u_clr;

    // split the address into page, queue index and user register fields
    always_comb begin
        aligned       = (bus_addr[1:0] == 2'b00);
        page          = bus_addr[ADDR_W-1:6];
        qsel          = bus_addr[5:2];
        in_user_space = (bus_addr[ADDR_W-1:8] != '0);
        uoff          = bus_addr - ADDR_W'(USER_BASE);
        usel          = uoff[ADDR_W-1:4];
        ukind         = ureg_e'(uoff[3:2]);
    end

    // queue bank with per-queue push/pop decode and event fan-in
    for (genvar m = 0; m < NUM_QUEUES; m++) begin : g_queue
        logic hit;
        assign hit       = aligned && !in_user_space && (page == PGW'(PAGE_MSG)) && (qsel == 4'(m));
        assign q_push[m] = bus_wr && hit;
        assign q_pop[m]  = bus_rd && hit;

        mbx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_i    (q_push[m]),
            .data_i    (bus_wdata),
            .pop_i     (q_pop[m]),
            .head_o    (q_head[m]),
            .count_o   (q_count[m]),
            .push_ok_o (q_push_ok[m]),
            .pop_ok_o  (q_pop_ok[m])
        );

        assign evt[2*m]   = q_push_ok[m];
        assign evt[2*m+1] = q_pop_ok[m];
    end

    // per-user interrupt blocks with their write strobes
    for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
        logic hit;
        assign hit      = bus_wr && aligned && in_user_space && (usel == (ADDR_W-4)'(u));
        assign u_w1c[u] = hit && (ukind == UREG_STATUS);
        assign u_set[u] = hit && (ukind == UREG_ENSET);
        assign u_clr[u] = hit && (ukind == UREG_ENCLR);

        mbx_user_irq #(.IW(IW)) i_user (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt),
            .w1c_we_i (u_w1c[u]),
            .set_we_i (u_set[u]),
            .clr_we_i (u_clr[u]),
            .wdata_i  (bus_wdata[IW-1:0]),
            .status_o (u_status[u]),
            .enable_o (u_enable[u]),
            .irq_o    (irq[u])
        );
    end

    // read multiplexer; unmapped and idle cycles return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && aligned) begin
            if (bus_addr == '0) begin
                bus_rdata = DATA_W'(REVISION);
            end else if (!in_user_space) begin
                for (int m = 0; m < NUM_QUEUES; m++) begin
                    if (qsel == 4'(m)) begin
                        if (page == PGW'(PAGE_MSG) && q_count[m] != '0)
                            bus_rdata = q_head[m];
                        else if (page == PGW'(PAGE_FULL))
                            bus_rdata[0] = (q_count[m] == CW'(DEPTH));
                        else if (page == PGW'(PAGE_COUNT))
                            bus_rdata[CW-1:0] = q_count[m];
                    end
                end
            end else begin
                for (int u = 0; u < NUM_USERS; u++) begin
                    if (usel == (ADDR_W-4)'(u)) begin
                        if (ukind == UREG_STATUS)
                            bus_rdata[IW-1:0] = u_status[u];
                        else if (ukind != UREG_NONE)
                            bus_rdata[IW-1:0] = u_enable[u];
                    end
                end
            end
        end
    end

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
    assert_one_event_per_queue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_push_ok) <= 1);
endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
    localparam int NU = 4, NQ = 8, DEPTH = 4;
    localparam logic [31:0] REV = 32'h0004_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NU-1:0] irq;

    int vectors = 0, miscompares = 0, cycles = 0;
    bit done = 0;

    int unsigned mq [NQ][$];
    logic [15:0] mst [NU];
    logic [15:0] men [NU];

    always #10 clk = ~clk;

    ipc_mailbox i_ipc_mailbox (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    // kind: 0 none,1 rev,2 msg,3 full,4 count,5 status,6 enset,7 enclr
    function automatic void decode(input logic [11:0] a, output int kind, output int idx);
        int off;
        kind = 0; idx = 0;
        if (a[1:0] != 0) return;
        if (a == 0) begin kind = 1; return; end
        if (a < 12'h100) begin
            idx = (a >> 2) & 15;
            if (idx >= NQ) return;
            case (a >> 6)
                1: kind = 2;
                2: kind = 3;
                3: kind = 4;
                default: kind = 0;
            endcase
        end else begin
            off = a - 12'h100;
            idx = off >> 4;
            if (idx >= NU) return;
            case ((off >> 2) & 3)
                1: kind = 5;
                2: kind = 6;
                3: kind = 7;
                default: kind = 0;
            endcase
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int k, i;
        decode(a, k, i);
        case (k)
            1: return REV;
            2: return (mq[i].size() > 0) ? mq[i][0] : 32'd0;
            3: return (mq[i].size() == DEPTH) ? 32'd1 : 32'd0;
            4: return mq[i].size();
            5: return {16'd0, mst[i]};
            6, 7: return {16'd0, men[i]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic void model_step(input logic wr, input logic rd, input logic [11:0] a,
                                       input logic [31:0] d);
        int k, i;
        bit push_ok = 0, pop_ok = 0;
        logic [15:0] ev = '0;
        decode(a, k, i);
        if (k == 2) begin
            push_ok = wr && (mq[i].size() < DEPTH);
            pop_ok  = rd && (mq[i].size() > 0);
            if (pop_ok)  begin void'(mq[i].pop_front()); ev[2*i+1] = 1'b1; end
            if (push_ok) begin mq[i].push_back(d);      ev[2*i]   = 1'b1; end
        end
        for (int u = 0; u < NU; u++) begin
            if (wr && k == 5 && i == u) mst[u] = (mst[u] & ~d[15:0]) | ev;
            else                        mst[u] = mst[u] | ev;
            if (wr && k == 6 && i == u) men[u] = men[u] | d[15:0];
            if (wr && k == 7 && i == u) men[u] = men[u] & ~d[15:0];
        end
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // one bus cycle, entered and left at a falling edge
    task automatic access(input logic wr, input logic rd, input logic [11:0] a,
                          input logic [31:0] d, input string tag);
        logic [NU-1:0] ei;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #5;
        check(bus_rdata, rd ? model_read(a) : 32'd0, tag);
        for (int u = 0; u < NU; u++) ei[u] = |(mst[u] & men[u]);
        check({28'd0, irq}, {28'd0, ei}, "R10 irq");
        @(posedge clk);
        model_step(wr, rd, a, d);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        access(1'b1, 1'b0, a, d, tag);
    endtask
    task automatic rd(input logic [11:0] a, input string tag);
        access(1'b0, 1'b1, a, 32'd0, tag);
    endtask

    function automatic logic [11:0] msg_a(input int m);   return 12'(12'h040 + 4*m); endfunction
    function automatic logic [11:0] full_a(input int m);  return 12'(12'h080 + 4*m); endfunction
    function automatic logic [11:0] cnt_a(input int m);   return 12'(12'h0C0 + 4*m); endfunction
    function automatic logic [11:0] st_a(input int u);    return 12'(12'h104 + 16*u); endfunction
    function automatic logic [11:0] set_a(input int u);   return 12'(12'h108 + 16*u); endfunction
    function automatic logic [11:0] clr_a(input int u);   return 12'(12'h10C + 16*u); endfunction

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // watchdog
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                miscompares++;
                $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        for (int u = 0; u < NU; u++) begin mst[u] = '0; men[u] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check({28'd0, irq}, 32'd0, "R1 irq after reset");
        for (int m = 0; m < NQ; m++) rd(cnt_a(m), "R1 empty queue");
        for (int u = 0; u < NU; u++) begin
            rd(st_a(u), "R1 status zero");
            rd(set_a(u), "R1 enable zero");
        end
        // R2 revision and ignored write
        rd(12'h000, "R2 revision");
        wr(12'h000, 32'hFFFF_FFFF, "R2 write");
        rd(12'h000, "R2 revision after write");
        // R9 enables
        wr(set_a(0), 32'h0000_FFFF, "R9 set");
        wr(clr_a(0), 32'h0000_00F0, "R9 clear");
        rd(set_a(0), "R9 read set reg");
        rd(clr_a(0), "R9 read clear reg");
        wr(set_a(2), 32'h0000_0002, "R9 set user2");
        // R3 fill queue 0 and R7 events
        for (int k = 0; k < 3; k++) wr(msg_a(0), 32'hA000_0000 + k, "R3 push");
        rd(cnt_a(0), "R6 count three");
        rd(full_a(0), "R5 not full");
        rd(st_a(1), "R7 newmsg on user1");
        wr(msg_a(0), 32'hA000_0003, "R3 push last");
        rd(full_a(0), "R5 full");
        rd(cnt_a(0), "R6 count four");
        wr(msg_a(0), 32'hDEAD_BEEF, "R4 write to full");
        rd(cnt_a(0), "R4 count after drop");
        for (int k = 0; k < 4; k++) rd(msg_a(0), "R3 pop order");
        rd(msg_a(0), "R4 empty read zero");
        rd(cnt_a(0), "R4 count after empty read");
        rd(st_a(3), "R7 notfull on user3");
        // R8 status clear
        wr(st_a(0), 32'h0, "R8 write zero");
        rd(st_a(0), "R8 unchanged");
        wr(st_a(0), 32'h0000_0001, "R8 clear bit0");
        rd(st_a(0), "R8 bit0 cleared");
        wr(st_a(0), 32'h0000_FFFF, "R8 clear all");
        rd(st_a(0), "R8 all cleared");
        // R12 simultaneous write/read
        access(1'b1, 1'b1, msg_a(2), 32'h1111_0001, "R12 rw on empty");
        rd(cnt_a(2), "R12 count one");
        wr(msg_a(2), 32'h1111_0002, "R3 push q2");
        access(1'b1, 1'b1, msg_a(2), 32'h1111_0003, "R12 rw returns head");
        rd(cnt_a(2), "R12 count stays");
        wr(msg_a(2), 32'h1111_0004, "R3 push q2");
        wr(msg_a(2), 32'h1111_0005, "R3 push q2");
        access(1'b1, 1'b1, msg_a(2), 32'h1111_0006, "R12 rw on full");
        rd(cnt_a(2), "R12 count after full rw");
        for (int k = 0; k < 4; k++) rd(msg_a(2), "R12 drain q2");
        // R11 unmapped
        wr(12'h100, 32'hFFFF_FFFF, "R11 gap write");
        wr(12'h110, 32'hFFFF_FFFF, "R11 gap write");
        wr(12'h060, 32'h5555_5555, "R11 queue beyond range");
        wr(12'h10A, 32'hFFFF_FFFF, "R11 misaligned");
        wr(12'h148, 32'hFFFF_FFFF, "R11 user beyond range");
        wr(12'h004, 32'hFFFF_FFFF, "R11 reserved");
        rd(12'h100, "R11 read gap");
        rd(12'h060, "R11 read beyond queue");
        rd(12'h10A, "R11 read misaligned");
        rd(12'h148, "R11 read beyond user");
        for (int u = 0; u < NU; u++) begin
            rd(set_a(u), "R11 enables untouched");
            rd(st_a(u), "R11 status untouched");
        end
        for (int m = 0; m < NQ; m++) rd(cnt_a(m), "R11 queues untouched");
        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int m = $urandom_range(NQ - 1);
            int u = $urandom_range(NU - 1);
            logic [31:0] d = $urandom;
            case ($urandom_range(8))
                0, 1: wr(msg_a(m), d, "R3 random push");
                2, 3: rd(msg_a(m), "R3 random pop");
                4: rd(full_a(m), "R5 random full");
                5: rd(cnt_a(m), "R6 random count");
                6: if (d[0]) wr(st_a(u), d, "R8 random clear");
                   else rd(st_a(u), "R7 random status");
                7: if (d[1]) wr(set_a(u), d, "R9 random set");
                   else wr(clr_a(u), d, "R9 random clear");
                default: access(1'b1, 1'b1, msg_a(m), d, "R12 random rw");
            endcase
        end
        finish_run();
    end
endmodule